// File: doc/BRIEF.md
# Immediate-Masked Packed Word Blend

This block is one pipeline stage of a wide SIMD datapath. It builds a result vector one 16-bit word at a time from two source vectors. An 8-bit immediate mask decides which source supplies each word. The datapath is split into 128-bit lanes of eight words each. The same mask byte steers every lane, so mask bit i picks word i within whichever lane it is applied to.

A 2-bit mode input picks how the part above the lowest lane is formed. There are three cases:

- In merge mode, the first source stands for the previous destination contents. Words whose mask bit is clear come from it, and its upper half passes through untouched.
- In clear mode, the upper half of the result is forced to zero.
- In wide mode, every lane is blended.

An operand set is accepted on any clock edge where `in_valid` is high. The result and `out_valid` appear on the next edge.

Top module: `word_blend_stage`

## Requirements
- R1: In every mode, word i of the lowest lane (result bits 16i+15:16i, i = 0..7) equals word i of `in_src_b` when `in_mask[i]` is 1, and word i of `in_src_a` when it is 0.
- R2: In wide mode (`in_mode` = 2'b10), word 8+i of the result is steered by `in_mask[i]` under the same rule as R1, so one mask bit controls the same word position in both lanes.
- R3: The reserved encoding `in_mode` = 2'b11 produces exactly the same result as wide mode.
- R4: In clear mode (`in_mode` = 2'b01), result bits 255:128 are all zero, whatever the operands and mask.
- R5: In merge mode (`in_mode` = 2'b00), result bits 255:128 equal bits 255:128 of `in_src_a`. In the lowest lane, a clear mask bit leaves that `in_src_a` word unchanged.
- R6: Operands, mode and mask sampled on a clock edge with `in_valid` high give `out_valid` high and the matching `out_result` on the next clock edge.
- R7: On a clock edge with `in_valid` low, `out_valid` goes low at the next edge and `out_result` keeps its previous value.
- R8: A synchronous active-high `rst` clears `out_valid` and `out_result` to zero at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand set present this cycle |
| in_mode | input | 2 | 00 merge, 01 clear, 10 wide, 11 reserved (acts as wide) |
| in_mask | input | 8 | Per-word source select, 1 = take `in_src_b` |
| in_src_a | input | 256 | First source; the old destination in merge mode |
| in_src_b | input | 256 | Second source |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_result | output | 256 | Registered blended result |

## Verification
The bench builds the block with its default parameters: 16-bit words, eight words per lane and two lanes. With that shape an 8-bit mask covers every mask value, so the bench applies all 256 masks with fresh random operands in each of the four mode encodings, including the reserved one. Idle cycles are mixed into the stream to exercise the hold behaviour. A reset in the middle of the run checks that the output returns to zero.

// File: rtl/wb_pkg.sv
package wb_pkg;
   // Mode encodings decoded by the upper-lane selector
   localparam logic [1:0] MODE_MERGE = 2'b00;
   localparam logic [1:0] MODE_CLEAR = 2'b01;
   localparam logic [1:0] MODE_WIDE  = 2'b10;
   localparam logic [1:0] MODE_RSVD  = 2'b11;
endpackage

// File: rtl/wb_lane_mux.sv
module wb_lane_mux #(
   parameter int WORD_W     = 16,
   parameter int LANE_WORDS = 8
) (
   input  logic [LANE_WORDS-1:0]        sel,
   input  logic [WORD_W*LANE_WORDS-1:0] lane_a,
   input  logic [WORD_W*LANE_WORDS-1:0] lane_b,
   output logic [WORD_W*LANE_WORDS-1:0] lane_y
);
   for (genvar w = 0; w < LANE_WORDS; w++) begin : g_word
      assign lane_y[w*WORD_W +: WORD_W] = sel[w] ? lane_b[w*WORD_W +: WORD_W]
                                                 : lane_a[w*WORD_W +: WORD_W];
   end
endmodule

// File: rtl/wb_upper_sel.sv
module wb_upper_sel
   import wb_pkg::*;
#(
   parameter int LANE_W = 128
) (
   input  logic [1:0]        mode,
   input  logic [LANE_W-1:0] blended,
   input  logic [LANE_W-1:0] old_val,
   output logic [LANE_W-1:0] lane_out
);
   always_comb begin
      unique case (mode)
         MODE_MERGE: lane_out = old_val;
         MODE_CLEAR: lane_out = '0;
         default:    lane_out = blended;   // wide and reserved
      endcase
   end
endmodule

// File: rtl/word_blend_stage.sv
module word_blend_stage
   import wb_pkg::*;
#(
   parameter int WORD_W     = 16,
   parameter int LANE_WORDS = 8,
   parameter int LANES      = 2
) (
   input  logic                                clk,
   input  logic                                rst,
   input  logic                                in_valid,
   input  logic [1:0]                          in_mode,
   input  logic [LANE_WORDS-1:0]               in_mask,
   input  logic [WORD_W*LANE_WORDS*LANES-1:0]  in_src_a,
   input  logic [WORD_W*LANE_WORDS*LANES-1:0]  in_src_b,
   output logic                                out_valid,
   output logic [WORD_W*LANE_WORDS*LANES-1:0]  out_result
);
   localparam int LANE_W = WORD_W * LANE_WORDS;
   localparam int DATA_W = LANE_W * LANES;

   if (WORD_W < 1)     begin : g_bad_word  $error("WORD_W must be positive");      end
   if (LANE_WORDS < 1) begin : g_bad_lane  $error("LANE_WORDS must be positive");  end
   if (LANES < 2)      begin : g_bad_lanes $error("LANES must be at least two");   end

   logic [DATA_W-1:0] nxt_result;

   // Lowest lane: always blended
   wb_lane_mux #(.WORD_W(WORD_W), .LANE_WORDS(LANE_WORDS)) u_lane0 (
      .sel    (in_mask),
      .lane_a (in_src_a[LANE_W-1:0]),
      .lane_b (in_src_b[LANE_W-1:0]),
      .lane_y (nxt_result[LANE_W-1:0])
   );

   // Upper lanes: blended, cleared or passed through depending on mode
   for (genvar l = 1; l < LANES; l++) begin : g_upper
      logic [LANE_W-1:0] mixed;
      wb_lane_mux #(.WORD_W(WORD_W), .LANE_WORDS(LANE_WORDS)) u_mix (
         .sel    (in_mask),
         .lane_a (in_src_a[l*LANE_W +: LANE_W]),
         .lane_b (in_src_b[l*LANE_W +: LANE_W]),
         .lane_y (mixed)
      );
      wb_upper_sel #(.LANE_W(LANE_W)) u_sel (
         .mode     (in_mode),
         .blended  (mixed),
         .old_val  (in_src_a[l*LANE_W +: LANE_W]),
         .lane_out (nxt_result[l*LANE_W +: LANE_W])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         out_result <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_result <= nxt_result;
      end
   end
endmodule

// File: rtl/wb_checker.sv
module wb_checker #(
   parameter int LANE_W = 128,
   parameter int DATA_W = 256,
   parameter int WORD_W = 16,
   parameter int MASK_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [1:0]        in_mode,
   input logic [MASK_W-1:0] in_mask,
   input logic [DATA_W-1:0] in_src_a,
   input logic [DATA_W-1:0] in_src_b,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_result
);
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);                                          // R6
   AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);                                        // R7
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_result));                               // R7
   AST_CLEAR_UPPER: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_mode == 2'b01) |=> out_result[DATA_W-1:LANE_W] == '0);  // R4
   AST_MERGE_UPPER: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_mode == 2'b00) |=>
         out_result[DATA_W-1:LANE_W] == $past(in_src_a[DATA_W-1:LANE_W]));    // R5
   AST_WORD0_SRC: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_mask[0]) |=> out_result[WORD_W-1:0] == $past(in_src_b[WORD_W-1:0])); // R1
   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (!out_valid && out_result == '0));                        // R8
endmodule

bind word_blend_stage wb_checker #(
   .LANE_W (WORD_W*LANE_WORDS),
   .DATA_W (WORD_W*LANE_WORDS*LANES),
   .WORD_W (WORD_W),
   .MASK_W (LANE_WORDS)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .in_valid   (in_valid),
   .in_mode    (in_mode),
   .in_mask    (in_mask),
   .in_src_a   (in_src_a),
   .in_src_b   (in_src_b),
   .out_valid  (out_valid),
   .out_result (out_result)
);

// File: tb/sim_word_blend_stage.sv
`timescale 1ns/1ps
module sim_word_blend_stage;
   localparam int W = 256;

   logic         clk = 1'b0;
   logic         rst;
   logic         in_valid;
   logic [1:0]   in_mode;
   logic [7:0]   in_mask;
   logic [W-1:0] in_src_a, in_src_b;
   logic         out_valid;
   logic [W-1:0] out_result;

   int vectors = 0;
   int fails   = 0;
   bit done    = 0;

   logic         exp_valid;
   logic [W-1:0] exp_result;

   always #10 clk = ~clk;   // 50 MHz

   word_blend_stage u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
      .in_mask(in_mask), .in_src_a(in_src_a), .in_src_b(in_src_b),
      .out_valid(out_valid), .out_result(out_result)
   );

   function automatic logic [W-1:0] rand_vec();
      logic [W-1:0] v;
      for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
      return v;
   endfunction

   function automatic logic [W-1:0] model(input logic [1:0] m, input logic [7:0] msk,
                                          input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W-1:0] r;
      for (int w = 0; w < 16; w++) begin
         if (w < 8 || m >= 2) r[w*16 +: 16] = msk[w % 8] ? b[w*16 +: 16] : a[w*16 +: 16];
         else if (m == 1)     r[w*16 +: 16] = 16'h0;
         else                 r[w*16 +: 16] = a[w*16 +: 16];
      end
      return r;
   endfunction

   function automatic string tags(input logic [1:0] m, input logic v, input logic r);
      if (r)      return "R8";
      if (!v)     return "R7";
      case (m)
         2'b00:   return "R1 R5 R6";
         2'b01:   return "R1 R4 R6";
         2'b10:   return "R1 R2 R6";
         default: return "R3 R2 R6";
      endcase
   endfunction

   // One clock: drive at negedge, let the edge pass, compare against the model
   task automatic step(input logic r, input logic v, input logic [1:0] m, input logic [7:0] msk,
                       input logic [W-1:0] a, input logic [W-1:0] b);
      string t;
      @(negedge clk);
      rst = r; in_valid = v; in_mode = m; in_mask = msk; in_src_a = a; in_src_b = b;
      t = tags(m, v, r);
      if (r) begin
         exp_valid = 1'b0; exp_result = '0;
      end else begin
         exp_valid = v;
         if (v) exp_result = model(m, msk, a, b);
      end
      @(posedge clk);
      #2;
      vectors++;
      if (out_valid !== exp_valid || out_result !== exp_result) begin
         fails++;
         $display("FAIL %s mode=%0d mask=%02h valid act=%0b exp=%0b result act=%h exp=%h",
                  t, m, msk, out_valid, exp_valid, out_result, exp_result);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; in_valid = 1'b0; in_mode = 2'b00; in_mask = 8'h00;
      in_src_a = '0; in_src_b = '0;
      // R8: reset state
      step(1'b1, 1'b0, 2'b00, 8'h00, '0, '0);
      step(1'b1, 1'b1, 2'b10, 8'hFF, rand_vec(), rand_vec());
      // Full mask sweep in every mode, idles mixed in for R7
      for (int m = 0; m < 4; m++) begin
         for (int k = 0; k < 256; k++) begin
            step(1'b0, 1'b1, m[1:0], k[7:0], rand_vec(), rand_vec());
            if (k % 37 == 5) step(1'b0, 1'b0, m[1:0], 8'hA5, rand_vec(), rand_vec());
         end
      end
      // Corner patterns: alternating masks on equal-position words (R2, R3)
      step(1'b0, 1'b1, 2'b11, 8'h55, {16{16'h1111}}, {16{16'hEEEE}});
      step(1'b0, 1'b1, 2'b01, 8'hFF, {16{16'hFFFF}}, {16{16'hFFFF}});
      step(1'b0, 1'b1, 2'b00, 8'h00, rand_vec(), rand_vec());
      step(1'b0, 1'b0, 2'b10, 8'hFF, rand_vec(), rand_vec());
      // R8: reset mid-run, then recovery
      step(1'b1, 1'b1, 2'b10, 8'h3C, rand_vec(), rand_vec());
      step(1'b0, 1'b0, 2'b10, 8'h3C, rand_vec(), rand_vec());
      step(1'b0, 1'b1, 2'b10, 8'hC3, rand_vec(), rand_vec());
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule